// File: doc/BRIEF.md
# Card Clock Generator with Ratio Select and Parked Stop

This block produces the clock for a smart card from the board's crystal. A two-bit select picks one of four ratios: the crystal frequency divided by eight, four or two, or the crystal frequency itself. A stop request parks the card clock at a programmed static level. The block is fully synchronous and runs from a core clock at twice the crystal frequency, so one crystal period is two core cycles. The card clock is always a register output, and every one of its edges falls on a core-clock rising edge.

The controls are plain level inputs that are sampled on every core clock. There is no stream data and no handshake. A ratio change only takes effect at the start of a card-clock period, which is the card clock's falling edge. A stop is entered only on the edge that brings the clock to the requested level. On release, the clock keeps the held level for a full half-period of the newly selected ratio before its next edge. As a result, no high or low phase is ever cut short.

Top module: `card_clk_gen`

## Requirements
- R1: While reset is asserted and after its release, the card clock is low, the internal count is cleared and the ratio is divide-by-8.
- R2: Select code 2'b00 (bit 1 is the first select bit) gives a card-clock period of 16 core cycles, 8 high and 8 low.
- R3: Select code 2'b01 gives a period of 8 core cycles, 4 high and 4 low.
- R4: Select code 2'b11 gives a period of 4 core cycles, 2 high and 2 low.
- R5: Select code 2'b10 gives the crystal frequency, toggling on every core cycle (1 high, 1 low).
- R6: A new select value is adopted only on a falling edge of the card clock, or on release from a stop. Every running phase lasts exactly half a period of one single ratio.
- R7: With the stop request high and the stop level at 1, the card clock runs on until its next rising edge and then stays high.
- R8: With the stop request high and the stop level at 0, the card clock runs on until its next falling edge and then stays low.
- R9: While the clock is parked and the stop request stays high, changes to the stop level or to the select have no effect on the card clock.
- R10: After the stop request falls, the card clock keeps the parked level for exactly one half-period of the ratio selected at release. The first edge after release comes only then, and there is no extra edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock at twice the crystal frequency |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_sel_i | input | 2 | Ratio select code (see R2 to R5) |
| stop_i | input | 1 | Request to park the card clock |
| stop_lvl_i | input | 1 | Parked level: 1 high, 0 low |
| card_clk_o | output | 1 | Card clock |

## Verification
A corrupted count or an active ratio register holding the wrong value shows up at the card clock as a phase of the wrong length. This appears by the next edge at the latest, which is within 8 core cycles at the slowest ratio. A stuck or stale parked flag shows as a card clock that either keeps toggling under a stop request or stays frozen after release. Both are visible within one half-period. The bench runs a behavioural model alongside the design and compares the card clock on every cycle, so any such divergence is flagged in the cycle it first appears.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;

  // Ratio select codes; bit 1 is the first select bit
  typedef enum logic [1:0] {
    SEL_DIV8 = 2'b00,
    SEL_DIV4 = 2'b01,
    SEL_DIV1 = 2'b10,
    SEL_DIV2 = 2'b11
  } div_sel_e;

endpackage

// File: rtl/card_clk_decode.sv
module card_clk_decode
  import card_clk_pkg::*;
#(
  parameter int XTAL_HALF = 1,
  parameter int CNT_W     = 4
) (
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] half_o
);

  // Half-period lengths in core cycles for each ratio
  localparam logic [CNT_W-1:0] HALF_D8 = CNT_W'(8 * XTAL_HALF);
  localparam logic [CNT_W-1:0] HALF_D4 = CNT_W'(4 * XTAL_HALF);
  localparam logic [CNT_W-1:0] HALF_D2 = CNT_W'(2 * XTAL_HALF);
  localparam logic [CNT_W-1:0] HALF_D1 = CNT_W'(XTAL_HALF);

  always_comb begin
    unique case (div_sel_e'(sel_i))
      SEL_DIV8: half_o = HALF_D8;
      SEL_DIV4: half_o = HALF_D4;
      SEL_DIV2: half_o = HALF_D2;
      SEL_DIV1: half_o = HALF_D1;
      default:  half_o = HALF_D8;
    endcase
  end

endmodule

// File: rtl/card_clk_phase.sv
module card_clk_phase #(
  parameter int XTAL_HALF = 1,
  parameter int CNT_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] half_new_i,
  output logic             lvl_o,
  output logic             boundary_o
);

  localparam logic [CNT_W-1:0] HALF_RST = CNT_W'(8 * XTAL_HALF);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_q;
  logic             lvl_q;

  assign boundary_o = ((cnt_q + 1'b1) == half_q);
  assign lvl_o      = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= HALF_RST;
      lvl_q  <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      half_q <= half_new_i;
    end else if (!hold_i) begin
      if (boundary_o) begin
        cnt_q <= '0;
        lvl_q <= ~lvl_q;
        // a period starts at the falling edge; adopt new ratio there
        if (lvl_q) half_q <= half_new_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R6
  ratio_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_q != $past(half_q)) |-> ($fell(lvl_q) || $past(restart_i)));

  // R10
  hold_freezes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(lvl_q));

endmodule

// File: rtl/card_clk_stop.sv
module card_clk_stop (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic stop_lvl_i,
  input  logic lvl_i,
  input  logic boundary_i,
  output logic hold_o,
  output logic restart_o
);

  logic frozen_q;
  logic enter;

  // park on the edge that brings the clock to the requested level
  assign enter     = ~frozen_q & boundary_i & stop_i & ((~lvl_i) == stop_lvl_i);
  assign hold_o    = frozen_q & stop_i;
  assign restart_o = frozen_q & ~stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        frozen_q <= 1'b0;
    else if (enter)     frozen_q <= 1'b1;
    else if (restart_o) frozen_q <= 1'b0;
  end

  // R7 R8
  freeze_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frozen_q) |-> (lvl_i == $past(stop_lvl_i)));

  // R9
  held_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_q && $past(frozen_q)) |-> $stable(lvl_i));

endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
  parameter int XTAL_HALF = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] div_sel_i,
  input  logic       stop_i,
  input  logic       stop_lvl_i,
  output logic       card_clk_o
);

  localparam int CNT_W = $clog2(8 * XTAL_HALF + 1);

  logic [CNT_W-1:0] half_new;
  logic             hold;
  logic             restart;
  logic             lvl;
  logic             boundary;

  card_clk_decode #(.XTAL_HALF(XTAL_HALF), .CNT_W(CNT_W)) u_decode (
    .sel_i  (div_sel_i),
    .half_o (half_new)
  );

  card_clk_phase #(.XTAL_HALF(XTAL_HALF), .CNT_W(CNT_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (hold),
    .restart_i  (restart),
    .half_new_i (half_new),
    .lvl_o      (lvl),
    .boundary_o (boundary)
  );

  card_clk_stop u_stop (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_i     (stop_i),
    .stop_lvl_i (stop_lvl_i),
    .lvl_i      (lvl),
    .boundary_i (boundary),
    .hold_o     (hold),
    .restart_o  (restart)
  );

  assign card_clk_o = lvl;

endmodule

// File: tb/card_clk_gen_tb.sv
module card_clk_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       stop = 1'b0;
  logic       lvl = 1'b0;
  logic       card_clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  bit started = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  card_clk_gen u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .div_sel_i  (sel),
    .stop_i     (stop),
    .stop_lvl_i (lvl),
    .card_clk_o (card_clk)
  );

  // behavioural reference model
  int m_out = 0, m_cnt = 0, m_half = 8, m_frz = 0;

  function automatic int half_of(logic [1:0] s);
    case (s)
      2'b00:   return 8;
      2'b01:   return 4;
      2'b11:   return 2;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_out = 0; m_cnt = 0; m_half = 8; m_frz = 0;
    end else if (m_frz != 0) begin
      if (!stop) begin
        m_frz = 0; m_cnt = 0; m_half = half_of(sel);
      end
    end else if (m_cnt + 1 == m_half) begin
      if (m_out == 1) m_half = half_of(sel);
      m_out = 1 - m_out;
      m_cnt = 0;
      if (stop && (m_out == int'(lvl))) m_frz = 1;
    end else begin
      m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      n_tests++;
      if (int'(card_clk) != m_out) begin
        n_fail++;
        $display("FAIL model compare (R2 R3 R4 R5 R6 R7 R8 R10) t=%0t actual=%0d expected=%0d",
                 $time, card_clk, m_out);
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(int exp, string req);
    logic prev;
    int hi = 0;
    int lo = 0;
    @(negedge clk); prev = card_clk;
    for (int g = 0; g < 100; g++) begin
      @(negedge clk);
      if (!prev && card_clk) break;
      prev = card_clk;
    end
    hi = 1;
    for (int g = 0; g < 100; g++) begin
      @(negedge clk);
      if (card_clk) hi++; else break;
    end
    lo = 1;
    for (int g = 0; g < 100; g++) begin
      @(negedge clk);
      if (!card_clk) lo++; else break;
    end
    check(hi == exp, {req, " high phase"}, hi, exp);
    check(lo == exp, {req, " low phase"}, lo, exp);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(card_clk == 1'b0, "R1 low in reset", int'(card_clk), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(card_clk == 1'b0, "R1 low after reset", int'(card_clk), 0);
    measure(8, "R1 R2 default div8");

    sel = 2'b01; repeat (40) @(negedge clk);
    measure(4, "R3 div4");
    sel = 2'b11; repeat (40) @(negedge clk);
    measure(2, "R4 div2");
    sel = 2'b10; repeat (40) @(negedge clk);
    measure(1, "R5 undivided");

    // R6: change ratio mid-phase, several times
    sel = 2'b00; repeat (3) @(negedge clk);
    sel = 2'b11; repeat (5) @(negedge clk);
    sel = 2'b01; repeat (40) @(negedge clk);
    measure(4, "R6 after mixed changes");
    sel = 2'b00; repeat (40) @(negedge clk);
    measure(8, "R2 R6 back to div8");

    // R7: park high
    stop = 1'b1; lvl = 1'b1;
    repeat (40) @(negedge clk);
    check(card_clk == 1'b1, "R7 parked high", int'(card_clk), 1);
    // R9: disturb level and select while parked
    lvl = 1'b0; sel = 2'b10;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(card_clk == 1'b1, "R9 parked ignores inputs", int'(card_clk), 1);
    end
    // R10: release with div8, expect 8 more high samples
    sel = 2'b00; stop = 1'b0;
    begin
      int n = 0;
      for (int g = 0; g < 100; g++) begin
        @(negedge clk);
        if (card_clk) n++; else break;
      end
      check(n == 8, "R10 resume holds level one half-period", n, 8);
    end

    // R8: park low at div4
    sel = 2'b01; repeat (20) @(negedge clk);
    stop = 1'b1; lvl = 1'b0;
    repeat (20) @(negedge clk);
    check(card_clk == 1'b0, "R8 parked low", int'(card_clk), 0);
    lvl = 1'b1; sel = 2'b11;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(card_clk == 1'b0, "R9 parked low ignores inputs", int'(card_clk), 0);
    end
    stop = 1'b0;
    repeat (10) @(negedge clk);
    measure(2, "R10 R4 running after release");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule